// File: doc/BRIEF.md
# Selectable-Polynomial CRC Accelerator

This block computes a running cyclic redundancy check over data that software writes to it through a small 32-bit register bus. A control register picks one of four generator polynomials (one 32-bit, three 16-bit), presets the accumulator to all zeros or all ones, and turns the engine on or off. Two aliases of the control register allow single bits to be set or cleared in one write.

Each data write feeds either one byte or a full word into the calculation. A word's bytes can first be swapped in 16-bit or 32-bit big-endian fashion, and the bits inside every byte can be mirrored. The CRC is computed MSB-first and non-reflected. The running value can be read directly, or read bit-mirrored through a second address. Every write is absorbed at a single clock edge, so a stream of data writes can arrive back to back with no stall.

Top module: `crc_accel`

## Requirements
- R1: A write with bit 0 set to the control register (offset 0x00) or to the set alias (0x04) loads the accumulator at that edge. The load value is 0xFFFFFFFF when control bit 1 is 1 after the write, and 0 when it is 0. Bit 0 itself is not stored.
- R2: While control bit 2 (enable) is 0, writes to the data register (0x10) leave the accumulator unchanged.
- R3: Control bits [5:4] choose the polynomial: 0 selects 32-bit 0x04C11DB7, 1 selects 16-bit 0x1021, 2 selects 16-bit 0x3D65, and 3 selects 16-bit 0x8005. Each byte is XORed into the top of the register and then shifted MSB-first for eight steps. The string "123456789" gives 0x0376E6E7 (32-bit, all-ones seed), 0x29B1 (0x1021, all-ones seed), 0x31C3 (0x1021, zero seed), 0xFEE8 (0x8005, zero seed) and 0x3D48 (0x3D65, zero seed).
- R4: bus_wsize=1 marks a word write, which processes all four bytes starting with bits [31:24] of the reordered word. bus_wsize=0 marks a byte write, which processes bits [7:0] only, and the byte-order field does not apply.
- R5: When control bit 8 is 1, every data write is handled as a byte write, whatever bus_wsize says.
- R6: When control bit 9 is 1, bit k of each input byte moves to bit 7-k before the byte enters the calculation.
- R7: Control bits [11:10] reorder the four bytes B3 B2 B1 B0 of a word write. Value 0 keeps them. Value 1 gives B2 B3 B0 B1. Value 2 gives B0 B1 B2 B3. Value 3 acts as 0.
- R8: A write to 0x04 ORs the written bits into the control register. A write to 0x08 clears every control bit that is written as 1.
- R9: Reads from 0x00, 0x04 and 0x08 return the control register. Only bits 1, 2, 4, 5, 8, 9, 10 and 11 are stored (mask 0xF36). All other bits, bit 0 included, read 0. Reads from unmapped offsets return 0.
- R10: In the 16-bit modes only accumulator bits [15:0] take part, and reads of 0x10 and 0x20 return 0 in bits [31:16].
- R11: A read of 0x10 returns the result. A read of 0x20 returns the result bit-mirrored: across 32 bits in the 32-bit mode, and across the low 16 bits in the 16-bit modes.
- R12: The accumulator changes only at the clock edge that samples a write. The new result can be read right after that edge, and before the edge the old result is still visible.
- R13: After reset the control register and the accumulator are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wsize | input | 1 | Access size of a data write: 1 = word, 0 = byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded from bus_addr without a clock |

## Verification
Read data is decoded from registers with no clock, so a control readback or a CRC result is due right after the rising edge that samples the write. Nothing is pipelined behind that edge. The bench drives every write on a falling edge and reads on the next falling edge, which puts each sample one full edge after the stimulus. One check samples the data address during a data write, both before and after the sampling edge, to confirm that the result moves at exactly that edge.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int HALF_W   = WORD_W / 2;

    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_0F36;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_SET  = 'h04;
    localparam int OFF_CLR  = 'h08;
    localparam int OFF_DATA = 'h10;
    localparam int OFF_REV  = 'h20;

    typedef struct packed {
        logic [1:0] order;
        logic       bit_rev;
        logic       force_byte;
        logic [1:0] poly;
        logic       enable;
        logic       seed_ones;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] poly_value(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'h04C1_1DB7;
            2'd1:    return 32'h0000_1021;
            2'd2:    return 32'h0000_3D65;
            default: return 32'h0000_8005;
        endcase
    endfunction

    function automatic logic poly_is_wide(input logic [1:0] sel);
        return sel == 2'd0;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[1]     = c.seed_ones;
        w[2]     = c.enable;
        w[5:4]   = c.poly;
        w[8]     = c.force_byte;
        w[9]     = c.bit_rev;
        w[11:10] = c.order;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.seed_ones  = w[1];
        c.enable     = w[2];
        c.poly       = w[5:4];
        c.force_byte = w[8];
        c.bit_rev    = w[9];
        c.order      = w[11:10];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] mirror_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/crc_input_stage.sv
module crc_input_stage
    import crc_accel_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              bit_rev,
    input  logic [1:0]        order,
    input  logic              byte_access,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] ordered;

    always_comb begin
        ordered = word_in;
        if (!byte_access) begin
            case (order)
                2'd1: ordered = {word_in[23:16], word_in[31:24], word_in[7:0], word_in[15:8]};
                2'd2: ordered = {word_in[7:0], word_in[15:8], word_in[23:16], word_in[31:24]};
                default: ordered = word_in;
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign word_out[g*BYTE_W + b] =
                bit_rev ? ordered[g*BYTE_W + (BYTE_W-1-b)] : ordered[g*BYTE_W + b];
        end
    end

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_accel_pkg::*;
(
    input  logic [WORD_W-1:0] crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [1:0]        poly_sel,
    output logic [WORD_W-1:0] crc_out
);

    logic [WORD_W-1:0] poly;
    logic              wide;

    assign poly = poly_value(poly_sel);
    assign wide = poly_is_wide(poly_sel);

    always_comb begin
        logic [WORD_W-1:0] c;
        logic              top;
        if (wide) c = crc_in ^ {byte_in, {(WORD_W-BYTE_W){1'b0}}};
        else      c = {{HALF_W{1'b0}}, crc_in[HALF_W-1:0] ^ {byte_in, {(HALF_W-BYTE_W){1'b0}}}};
        for (int i = 0; i < BYTE_W; i++) begin
            top = wide ? c[WORD_W-1] : c[HALF_W-1];
            c   = {c[WORD_W-2:0], 1'b0} ^ (top ? poly : '0);
            if (!wide) c[WORD_W-1:HALF_W] = '0;
        end
        crc_out = c;
    end

endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_accel_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wsize,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [WORD_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    logic hit_ctrl, hit_set, hit_clr, hit_data, hit_rev;
    assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
    assign hit_set  = bus_addr == ADDR_W'(OFF_SET);
    assign hit_clr  = bus_addr == ADDR_W'(OFF_CLR);
    assign hit_data = bus_addr == ADDR_W'(OFF_DATA);
    assign hit_rev  = bus_addr == ADDR_W'(OFF_REV);

    logic byte_access;
    assign byte_access = !bus_wsize || st_q.ctrl.force_byte;

    logic [WORD_W-1:0] prepped;

    crc_input_stage u_in (
        .word_in    (bus_wdata),
        .bit_rev    (st_q.ctrl.bit_rev),
        .order      (st_q.ctrl.order),
        .byte_access(byte_access),
        .word_out   (prepped)
    );

    logic [LANES:0][WORD_W-1:0] chain;
    logic [LANES-1:0][BYTE_W-1:0] feed;
    assign chain[0] = st_q.acc;

    for (genvar k = 0; k < LANES; k++) begin : g_step
        if (k == 0) begin : g_first
            assign feed[k] = byte_access ? prepped[BYTE_W-1:0]
                                         : prepped[(LANES-1)*BYTE_W +: BYTE_W];
        end else begin : g_rest
            assign feed[k] = prepped[(LANES-1-k)*BYTE_W +: BYTE_W];
        end
        crc_byte_step u_step (
            .crc_in  (chain[k]),
            .byte_in (feed[k]),
            .poly_sel(st_q.ctrl.poly),
            .crc_out (chain[k+1])
        );
    end

    logic [WORD_W-1:0] crc_next;
    assign crc_next = byte_access ? chain[1] : chain[LANES];

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (hit_ctrl) st_d.ctrl = word_to_ctrl(bus_wdata);
            if (hit_set)  st_d.ctrl = word_to_ctrl(ctrl_to_word(st_q.ctrl) | bus_wdata);
            if (hit_clr)  st_d.ctrl = word_to_ctrl(ctrl_to_word(st_q.ctrl) & ~bus_wdata);
            if ((hit_ctrl || hit_set) && bus_wdata[0]) begin
                st_d.acc = st_d.ctrl.seed_ones ? '1 : '0;
            end else if (hit_data && st_q.ctrl.enable) begin
                st_d.acc = crc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [WORD_W-1:0] result, result_rev;

    always_comb begin
        if (poly_is_wide(st_q.ctrl.poly)) begin
            result     = st_q.acc;
            result_rev = mirror_word(st_q.acc);
        end else begin
            result     = {{HALF_W{1'b0}}, st_q.acc[HALF_W-1:0]};
            result_rev = mirror_word({st_q.acc[HALF_W-1:0], {HALF_W{1'b0}}});
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl || hit_set || hit_clr) bus_rdata = ctrl_to_word(st_q.ctrl);
        else if (hit_data)                  bus_rdata = result;
        else if (hit_rev)                   bus_rdata = result_rev;
    end

endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk
    import crc_accel_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] acc,
    input logic              en,
    input logic [1:0]        poly
);

    // R1: seed strobe with all-ones select
    a_r1_seed_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[0] && bus_wdata[1])
        |=> acc == '1);

    // R1: seed strobe with all-zeros select
    a_r1_seed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[0] && !bus_wdata[1])
        |=> acc == '0);

    // R2: disabled engine ignores data writes
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DATA) && !en) |=> $stable(acc));

    // R9: seed strobe never reads back
    a_r9_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTRL)) |-> !bus_rdata[0]);

    // R10: upper half is zero in the 16-bit modes
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (poly != 2'd0 && (bus_addr == ADDR_W'(OFF_DATA) || bus_addr == ADDR_W'(OFF_REV)))
        |-> bus_rdata[WORD_W-1:HALF_W] == '0);

    // R12: no write, no change
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(acc));

endmodule

bind crc_accel crc_accel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .acc      (st_q.acc),
    .en       (st_q.ctrl.enable),
    .poly     (st_q.ctrl.poly)
);

// File: tb/tb_crc_accel.sv
module tb_crc_accel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wsize = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] m_ctrl = '0;
    logic [31:0] m_acc  = '0;

    crc_accel dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wsize(bus_wsize), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] m_poly(input logic [1:0] s);
        case (s)
            2'd0: return 32'h04C11DB7;
            2'd1: return 32'h1021;
            2'd2: return 32'h3D65;
            default: return 32'h8005;
        endcase
    endfunction

    function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] b,
                                           input logic [1:0] s);
        logic [31:0] r;
        if (s == 2'd0) begin
            r = c ^ (32'(b) << 24);
            for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ m_poly(s)) : (r << 1);
        end else begin
            r = (c & 32'hFFFF) ^ (32'(b) << 8);
            for (int i = 0; i < 8; i++) r = (r[15] ? ((r << 1) ^ m_poly(s)) : (r << 1)) & 32'hFFFF;
        end
        return r;
    endfunction

    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] exp_res(input logic [31:0] a, input logic [31:0] c);
        return (c[5:4] == 2'd0) ? a : (a & 32'hFFFF);
    endfunction

    function automatic logic [31:0] exp_rev(input logic [31:0] a, input logic [31:0] c);
        logic [31:0] r;
        r = '0;
        if (c[5:4] == 2'd0) for (int i = 0; i < 32; i++) r[i] = a[31-i];
        else                for (int i = 0; i < 16; i++) r[i] = a[15-i];
        return r;
    endfunction

    // model of one bus write, following the requirements
    task automatic model_write(input logic [5:0] a, input logic [31:0] d, input logic sz);
        logic [7:0] bs [4];
        if (a == 6'h00) m_ctrl = d & 32'hF36;
        if (a == 6'h04) m_ctrl = m_ctrl | (d & 32'hF36);
        if (a == 6'h08) m_ctrl = m_ctrl & ~d;
        if ((a == 6'h00 || a == 6'h04) && d[0]) begin
            m_acc = m_ctrl[1] ? 32'hFFFFFFFF : 32'h0;
        end else if (a == 6'h10 && m_ctrl[2]) begin
            if (!sz || m_ctrl[8]) begin
                m_acc = m_byte(m_acc, m_ctrl[9] ? flip8(d[7:0]) : d[7:0], m_ctrl[5:4]);
            end else begin
                case (m_ctrl[11:10])
                    2'd1: begin bs[0] = d[23:16]; bs[1] = d[31:24]; bs[2] = d[7:0];   bs[3] = d[15:8];  end
                    2'd2: begin bs[0] = d[7:0];   bs[1] = d[15:8];  bs[2] = d[23:16]; bs[3] = d[31:24]; end
                    default: begin bs[0] = d[31:24]; bs[1] = d[23:16]; bs[2] = d[15:8]; bs[3] = d[7:0]; end
                endcase
                for (int i = 0; i < 4; i++)
                    m_acc = m_byte(m_acc, m_ctrl[9] ? flip8(bs[i]) : bs[i], m_ctrl[5:4]);
            end
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic sz);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wsize = sz;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d, sz);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_result(input string req);
        logic [31:0] v;
        rd(6'h10, v); check(req, v, exp_res(m_acc, m_ctrl));
        rd(6'h20, v); check(req, v, exp_rev(m_acc, m_ctrl));
    endtask

    task automatic feed_digits(input logic [31:0] cfg);
        wr(6'h00, cfg, 1'b0);
        for (int i = 0; i < 9; i++) wr(6'h10, 32'h31 + 32'(i), 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        rd(6'h00, v); check("R13 ctrl after reset", v, 32'h0);
        rd(6'h10, v); check("R13 result after reset", v, 32'h0);

        // R9: writable mask, strobe reads zero; R10: 16-bit readback of all-ones seed
        wr(6'h00, 32'hFFFFFFFF, 1'b1);
        rd(6'h00, v); check("R9 ctrl mask", v, 32'h00000F36);
        rd(6'h10, v); check("R10 16-bit result of all-ones seed", v, 32'h0000FFFF);
        rd(6'h20, v); check("R11 16-bit mirrored", v, 32'h0000FFFF);
        rd(6'h14, v); check("R9 unmapped read", v, 32'h0);

        // R8: clear and set aliases
        wr(6'h08, 32'hFFFFFFFF, 1'b1);
        rd(6'h04, v); check("R8 clear alias", v, 32'h0);
        wr(6'h04, 32'h4, 1'b1);
        wr(6'h04, 32'h30, 1'b1);
        rd(6'h08, v); check("R8 set alias", v, 32'h34);
        wr(6'h08, 32'h4, 1'b1);
        rd(6'h00, v); check("R8 clear one bit", v, 32'h30);

        // R1: seed through set alias
        wr(6'h04, 32'h3, 1'b1);
        rd(6'h10, v); check("R1 seed via set alias", v, 32'h0000FFFF);

        // R3: check values of "123456789"
        feed_digits(32'h007); rd(6'h10, v); check("R3 crc32 check value", v, 32'h0376E6E7);
        feed_digits(32'h017); rd(6'h10, v); check("R3 0x1021 ones check value", v, 32'h29B1);
        feed_digits(32'h015); rd(6'h10, v); check("R3 0x1021 zero check value", v, 32'h31C3);
        feed_digits(32'h035); rd(6'h10, v); check("R3 0x8005 check value", v, 32'hFEE8);
        feed_digits(32'h025); rd(6'h10, v); check("R3 0x3D65 check value", v, 32'h3D48);

        // R4/R7: words in 32-bit swapped order give the same check value
        wr(6'h00, 32'h807, 1'b1);
        wr(6'h10, 32'h34333231, 1'b1);
        wr(6'h10, 32'h38373635, 1'b1);
        wr(6'h10, 32'h00000039, 1'b0);
        rd(6'h10, v); check("R4 R7 word path check value", v, 32'h0376E6E7);
        check_result("R11 mirrored after words");

        // R2: disabled engine ignores data
        wr(6'h08, 32'h4, 1'b1);
        wr(6'h10, 32'hDEADBEEF, 1'b1);
        rd(6'h10, v); check("R2 disabled hold", v, 32'h0376E6E7);

        // R5: forced byte mode
        wr(6'h00, 32'h107, 1'b1);
        wr(6'h10, 32'hA5C3_5A17, 1'b1);
        check_result("R5 forced byte mode");

        // R12: result moves exactly at the write edge
        @(negedge clk);
        w = exp_res(m_acc, m_ctrl);
        bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h0000_0042; bus_wsize = 1'b1;
        #1 check("R12 old result before edge", bus_rdata, w);
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(6'h10, 32'h0000_0042, 1'b1);
        check("R12 new result after edge", bus_rdata, exp_res(m_acc, m_ctrl));

        // R3/R6/R7/R11 sweep over every configuration
        for (int sel = 0; sel < 4; sel++)
            for (int sd = 0; sd < 2; sd++)
                for (int rv = 0; rv < 2; rv++)
                    for (int od = 0; od < 4; od++) begin
                        w = 32'h5 | (32'(sd) << 1) | (32'(sel) << 4) | (32'(rv) << 9) | (32'(od) << 10);
                        wr(6'h00, w, 1'b1);
                        wr(6'h10, 32'h9E3779B9 * 32'(sel*16 + sd*8 + rv*4 + od + 1), 1'b1);
                        wr(6'h10, 32'h01234567 ^ 32'(od << 24) ^ 32'(sel << 8), 1'b1);
                        wr(6'h10, 32'h000000C1 + 32'(rv), 1'b0);
                        check_result("R3 R6 R7 R11 sweep");
                    end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule